// File: doc/BRIEF.md
# Fault Input Conditioner and Reaction Unit

This block watches a single fault input belonging to one PWM module and decides when that module's outputs must be suppressed. The input comes from either an external pin or an internal comparator result, and it can be active high or active low. A glitch filter, which can be switched off for a faster reaction, removes short spikes. The conditioned level then drives one of two reactions. In gate mode, one chosen output is forced inactive only while the input is active. In halt mode, the input latches a fault that stops the generator until software restarts it.

The block also produces a one-clock event pulse on each activation, for use as an interrupt request. A second, unclocked path carries the selected input straight to the output kill lines, so that the outputs can be suppressed even while the clock is stopped. The comparator and the PWM counter are outside this block.

Top module: `fault_guard`

## Requirements
- R1: With `cfg_src_cmp`=1 the comparator input is used. With `cfg_src_cmp`=0 the pin input is used, and it first passes a two-flop synchronizer, so an unfiltered pin change reaches the registered outputs on the third rising edge after it.
- R2: With `cfg_active_high`=1 a high input level is active. With `cfg_active_high`=0 a low input level is active.
- R3: With `cfg_filter_en`=0 an unfiltered comparator change reaches the registered outputs at the first rising edge that samples it.
- R4: With `cfg_filter_en`=1 a new level is accepted only after it has been sampled on 4 consecutive edges. This adds exactly 4 clocks of delay, so a comparator change reaches the outputs at the fifth edge.
- R5: With the filter on, an active pulse lasting 3 clocks never reaches any output. With the filter off, the same pulse reaches the outputs.
- R6: In gate mode (`cfg_halt_mode`=0), only the output chosen by `cfg_target_b` is killed (0 selects A, 1 selects B). It is killed only while the conditioned input is active and is released once that input goes inactive.
- R7: In halt mode (`cfg_halt_mode`=1), an active conditioned input sets `halt` and kills both outputs. They stay set after the input goes inactive, until a `sw_restart` pulse clears them.
- R8: A `sw_restart` that arrives while the conditioned input is still active has no effect.
- R9: `fault_evt` is high for exactly one clock, in the cycle in which the conditioned input first becomes active.
- R10: With `cfg_async_en`=1, an active selected raw input kills the target output combinationally, with no clock edge needed.
- R11: While reset is held and after reset, with the input inactive, `kill_a`, `kill_b`, `halt` and `fault_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External fault pin, asynchronous |
| cmp_in | input | 1 | Internal comparator result, synchronous |
| cfg_src_cmp | input | 1 | 1 selects the comparator, 0 selects the pin |
| cfg_active_high | input | 1 | 1 means a high level is active |
| cfg_filter_en | input | 1 | Enables the 4-clock glitch filter |
| cfg_halt_mode | input | 1 | 0 selects gate mode, 1 selects latched halt mode |
| cfg_target_b | input | 1 | Gate-mode target: 0 selects output A, 1 selects output B |
| cfg_async_en | input | 1 | Enables the unclocked kill path |
| sw_restart | input | 1 | Software restart request for a latched fault |
| kill_a | output | 1 | Force PWM output A inactive |
| kill_b | output | 1 | Force PWM output B inactive |
| halt | output | 1 | Stop the PWM counter |
| fault_evt | output | 1 | One-clock fault event pulse |

## Verification
The hardest cases to reach are those that depend on the exact length of a pulse relative to the filter window. One is a 3-clock spike, which must vanish with the filter on and must appear with it off. The other is a restart request that overlaps a still-active input. The stimulus drives inputs on falling edges, so a pulse spans an exact number of sampling edges. A scoreboard queue holds the expected output values for each absolute cycle, including the empty cycles through which a filtered spike must not leak. The unclocked path is checked a nanosecond after a pin change, before any rising edge can occur.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } src_e;

    typedef enum logic {
        RX_GATE = 1'b0,
        RX_HALT = 1'b1
    } react_e;

    typedef struct packed {
        logic inp;
        logic fault;
        logic evt;
    } react_st_t;

endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/fault_filter.sv
module fault_filter #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic out
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = en ? st_q.lvl : raw;
endmodule

// File: rtl/fault_react.sv
module fault_react
    import fault_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      act,
    input  react_e    mode,
    input  logic      restart,
    output react_st_t st
);
    react_st_t st_d, st_q;

    always_comb begin
        st_d.inp   = act;
        st_d.evt   = act & ~st_q.inp;
        st_d.fault = (mode == RX_HALT) & (act | (st_q.fault & ~restart));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fault_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_WIN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic cmp_in,
    input  logic cfg_src_cmp,
    input  logic cfg_active_high,
    input  logic cfg_filter_en,
    input  logic cfg_halt_mode,
    input  logic cfg_target_b,
    input  logic cfg_async_en,
    input  logic sw_restart,
    output logic kill_a,
    output logic kill_b,
    output logic halt,
    output logic fault_evt
);
    logic      pin_sync;
    logic      sel_sync;
    logic      act_sync;
    logic      filt_act;
    logic      raw_act;
    logic      async_kill;
    src_e      src;
    react_e    mode;
    react_st_t rst_st;

    assign src  = src_e'(cfg_src_cmp);
    assign mode = react_e'(cfg_halt_mode);

    fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_sync)
    );

    assign sel_sync = (src == SRC_CMP) ? cmp_in : pin_sync;
    assign act_sync = sel_sync ^ ~cfg_active_high;

    fault_filter #(.WIN(FILT_WIN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_filter_en),
        .raw   (act_sync),
        .out   (filt_act)
    );

    fault_react u_react (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (filt_act),
        .mode    (mode),
        .restart (sw_restart),
        .st      (rst_st)
    );

    assign raw_act    = ((src == SRC_CMP) ? cmp_in : pin_in) ^ ~cfg_active_high;
    assign async_kill = cfg_async_en & raw_act;

    always_comb begin
        if (mode == RX_HALT) begin
            kill_a = rst_st.fault;
            kill_b = rst_st.fault;
        end else begin
            kill_a = rst_st.inp & ~cfg_target_b;
            kill_b = rst_st.inp &  cfg_target_b;
        end
        kill_a = kill_a | (async_kill & ~cfg_target_b);
        kill_b = kill_b | (async_kill &  cfg_target_b);
    end

    assign halt      = rst_st.fault;
    assign fault_evt = rst_st.evt;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_mode,
    input logic restart,
    input logic async_en,
    input logic filt_act,
    input logic kill_a,
    input logic kill_b,
    input logic halt,
    input logic evt
);
    p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    p_evt_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (kill_a || kill_b));

    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && filt_act && halt_mode) |=> halt);

    p_halt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt) |-> ($past(restart) || !$past(halt_mode)));

    p_gate_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_mode && !async_en) |-> $countones({kill_a, kill_b}) <= 1);

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r11: assert (!halt && !evt);
        end
    end
endmodule

bind fault_guard fault_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_mode (cfg_halt_mode),
    .restart   (sw_restart),
    .async_en  (cfg_async_en),
    .filt_act  (filt_act),
    .kill_a    (kill_a),
    .kill_b    (kill_b),
    .halt      (halt),
    .evt       (fault_evt)
);

// File: tb/test_fault_guard.sv
module test_fault_guard;
    logic clk = 0;
    logic rst_n = 0;
    logic pin_in = 0, cmp_in = 0;
    logic cfg_src_cmp = 1, cfg_active_high = 1, cfg_filter_en = 0;
    logic cfg_halt_mode = 0, cfg_target_b = 0, cfg_async_en = 0;
    logic sw_restart = 0;
    logic kill_a, kill_b, halt, fault_evt;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        int    at;
        logic  ka, kb, h, ev;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    fault_guard i_fault_guard (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
        .cfg_src_cmp(cfg_src_cmp), .cfg_active_high(cfg_active_high),
        .cfg_filter_en(cfg_filter_en), .cfg_halt_mode(cfg_halt_mode),
        .cfg_target_b(cfg_target_b), .cfg_async_en(cfg_async_en),
        .sw_restart(sw_restart), .kill_a(kill_a), .kill_b(kill_b),
        .halt(halt), .fault_evt(fault_evt)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: got {ka,kb,halt,evt}=%b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic expect_at(input int d, input logic ka, kb, h, ev, input string tag);
        exp_t e;
        e.at = cyc + d; e.ka = ka; e.kb = kb; e.h = h; e.ev = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pops expectations due on this cycle
    initial forever begin
        @(posedge clk);
        cyc++;
        #2;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, {kill_a, kill_b, halt, fault_evt}, {e.ka, e.kb, e.h, e.ev});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        wait_neg(3);
        chk("R11 reset", {kill_a, kill_b, halt, fault_evt}, 4'b0000);
        rst_n = 1;
        wait_neg(2);
        chk("R11 after reset", {kill_a, kill_b, halt, fault_evt}, 4'b0000);

        // R3 R6 R9: gate A, filter bypassed, comparator source
        cmp_in = 1;
        expect_at(1, 1, 0, 0, 1, "R3 R9 gate A unfiltered");
        expect_at(2, 1, 0, 0, 0, "R9 event one clock");
        wait_neg(3);
        cmp_in = 0;
        expect_at(1, 0, 0, 0, 0, "R6 release A");
        wait_neg(3);

        // R6: target B
        cfg_target_b = 1;
        wait_neg(1);
        cmp_in = 1;
        expect_at(1, 0, 1, 0, 1, "R6 gate B only");
        wait_neg(3);
        cmp_in = 0;
        expect_at(1, 0, 0, 0, 0, "R6 release B");
        wait_neg(3);

        // R5: 3-clock spike blocked with filter on
        cfg_filter_en = 1;
        wait_neg(2);
        for (int d = 1; d <= 8; d++) expect_at(d, 0, 0, 0, 0, "R5 spike blocked");
        cmp_in = 1;
        wait_neg(3);
        cmp_in = 0;
        wait_neg(8);

        // R4: held level accepted after filter window
        cmp_in = 1;
        expect_at(4, 0, 0, 0, 0, "R4 not yet accepted");
        expect_at(5, 0, 1, 0, 1, "R4 accepted at fifth edge");
        wait_neg(8);
        cmp_in = 0;
        expect_at(4, 0, 1, 0, 0, "R4 release delayed");
        expect_at(5, 0, 0, 0, 0, "R4 release");
        wait_neg(8);

        // R5: same spike passes with filter off
        cfg_filter_en = 0;
        wait_neg(2);
        cmp_in = 1;
        expect_at(1, 0, 1, 0, 1, "R5 spike passes unfiltered");
        expect_at(3, 0, 1, 0, 0, "R5 spike held");
        expect_at(4, 0, 0, 0, 0, "R5 spike ends");
        wait_neg(3);
        cmp_in = 0;
        wait_neg(4);

        // R2: active low
        cmp_in = 1; cfg_active_high = 0;
        expect_at(1, 0, 0, 0, 0, "R2 high inactive when active low");
        wait_neg(2);
        cmp_in = 0;
        expect_at(1, 0, 1, 0, 1, "R2 low active");
        wait_neg(3);
        cmp_in = 1;
        expect_at(1, 0, 0, 0, 0, "R2 release");
        wait_neg(2);
        cmp_in = 0; cfg_active_high = 1;
        wait_neg(3);

        // R1: pin source with synchronizer
        cfg_src_cmp = 0; cfg_target_b = 0;
        wait_neg(2);
        pin_in = 1;
        expect_at(2, 0, 0, 0, 0, "R1 sync latency");
        expect_at(3, 1, 0, 0, 1, "R1 pin via sync");
        wait_neg(5);
        pin_in = 0;
        expect_at(3, 0, 0, 0, 0, "R1 pin release");
        wait_neg(5);

        // R7 R8: halt mode
        cfg_src_cmp = 1; cfg_halt_mode = 1;
        wait_neg(2);
        cmp_in = 1;
        expect_at(1, 1, 1, 1, 1, "R7 halt latched");
        wait_neg(3);
        sw_restart = 1;
        expect_at(1, 1, 1, 1, 0, "R8 restart ignored while active");
        wait_neg(1);
        sw_restart = 0;
        cmp_in = 0;
        expect_at(2, 1, 1, 1, 0, "R7 held after input inactive");
        wait_neg(4);
        sw_restart = 1;
        expect_at(1, 0, 0, 0, 0, "R7 restart clears");
        wait_neg(1);
        sw_restart = 0;
        wait_neg(3);
        cfg_halt_mode = 0;
        wait_neg(2);

        // R10: unclocked path
        cfg_src_cmp = 0; cfg_async_en = 1;
        wait_neg(1);
        pin_in = 1;
        #1;
        chk("R10 async kill A", {kill_a, kill_b, halt, fault_evt}, 4'b1000);
        pin_in = 0;
        #1;
        chk("R10 async release", {kill_a, kill_b, halt, fault_evt}, 4'b0000);
        wait_neg(5);
        chk("R10 short pin ignored by clocked path", {kill_a, kill_b, halt, fault_evt}, 4'b0000);

        wait_neg(2);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        finish_run();
    end
endmodule